// File: doc/BRIEF.md
# Bus-Loaded Multichannel Countdown Timer

This block is a bank of independent down-counters that share one clock. A processor writes each channel's start value through a simple synchronous write port: address, data and a write strobe. Every channel drives one output bit. That bit is high while the channel counts down and low at all other times.

Loading a channel does not start it. All loaded channels start together, one clock after the processor writes the highest-numbered channel. That write loads its own channel and arms the whole bank. Once a channel has expired, its output stays low. Later arming writes leave it low until the processor loads it again. A typical setup writes the channels in ascending order, so the final write launches the whole set. The counters are meant for a clock in the tens of megahertz.

Each channel runs a four-state machine. IDLE is the state after reset. LOADED holds a value and waits for the start. RUN counts with its output high. EXPIRED has finished and waits for a reload. The transitions are:
- LOAD: a write addressed to the channel, from any state, goes to LOADED.
- START: arm seen in LOADED with a nonzero value goes to RUN.
- SKIP: arm seen in LOADED with a zero value goes to EXPIRED.
- TICK: a count above one in RUN stays in RUN and decrements.
- END: a count of one in RUN goes to EXPIRED.

Top module: `mct_bank`

## Requirements
- R1: While reset is asserted and right after it, every channel output is low.
- R2: A write with address k below the channel count loads the write data as channel k's count. The channel's output stays low while it waits for the start.
- R3: A write to an address equal to or above the channel count changes no channel. No output starts because of it.
- R4: A write to address N_CH-1 arms the bank. On the clock edge after that write, every channel in LOADED with a nonzero value raises its output.
- R5: A channel loaded with value N (N > 0) keeps its output high for exactly N clock cycles after the common start edge.
- R6: A channel loaded with zero never raises its output.
- R7: An expired channel's output stays low through later arming writes until that channel is written again.
- R8: A write to a channel while it runs stops it at once: its output is low from the following cycle. The new value waits for the next arm.
- R9: A channel never written since reset stays low when the bank is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for bus and counters |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| wr_addr | input | ADDR_W | Channel select; values of N_CH and above are ignored |
| wr_data | input | CNT_W | Start value for the selected channel |
| tmr_out | output | N_CH | One bit per channel, high while that channel counts |

## Verification
The bench sweeps every channel at once with distinct lengths, including zero, and checks each output cycle by cycle against a window computed from the loaded value. A design that is off by one in either direction makes an output rise early or fall a cycle early or late. A design that starts a channel on its own load, instead of on the arming write, shows a high output before the arm. The bench also writes every address above the channel range. A decoder that aliases those addresses onto low channels would start those channels. Other checks re-arm without reloading, reload a channel in mid-run, and arm right after reset. These catch a machine that restarts from EXPIRED, keeps running after a reload, or starts a channel that was never written.

// File: rtl/mct_pkg.sv
package mct_pkg;
    typedef enum logic [1:0] {
        CH_IDLE    = 2'd0,
        CH_LOADED  = 2'd1,
        CH_RUN     = 2'd2,
        CH_EXPIRED = 2'd3
    } ch_state_e;
endpackage

// File: rtl/mct_decode.sv
module mct_decode #(
    parameter int N_CH   = 12,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [N_CH-1:0]   ld_vec,
    output logic              arm
);
    localparam int LAST = N_CH - 1;

    for (genvar c = 0; c < N_CH; c++) begin : g_sel
        assign ld_vec[c] = wr_en && (wr_addr == ADDR_W'(c));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arm <= 1'b0;
        else        arm <= wr_en && (wr_addr == ADDR_W'(LAST));
    end

    AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ld_vec)); // R2
    AST_ARM_FROM_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        ld_vec[LAST] |=> arm); // R4
    AST_NO_ARM_WITHOUT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_vec[LAST] |=> !arm); // R3
endmodule

// File: rtl/mct_channel.sv
module mct_channel
    import mct_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             arm,
    output logic             tmr_out
);
    ch_state_e        st, st_nx;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        st_nx = st;
        if (ld) begin
            st_nx = CH_LOADED;
        end else begin
            unique case (st)
                CH_IDLE:    st_nx = CH_IDLE;
                CH_LOADED:  if (arm) st_nx = (cnt == '0) ? CH_EXPIRED : CH_RUN;
                CH_RUN:     if (cnt == CNT_W'(1)) st_nx = CH_EXPIRED;
                CH_EXPIRED: st_nx = CH_EXPIRED;
                default:    st_nx = CH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= CH_IDLE;
            cnt <= '0;
        end else begin
            st <= st_nx;
            if (ld)                cnt <= ld_val;
            else if (st == CH_RUN) cnt <= cnt - CNT_W'(1);
        end
    end

    always_comb tmr_out = (st == CH_RUN);

    AST_RUN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CH_RUN) |-> (cnt != '0)); // R6
    AST_RISE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_out) |-> $past(arm)); // R4
    AST_RUN_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CH_RUN && !ld && cnt > CNT_W'(1)) |=> (tmr_out && cnt == $past(cnt) - CNT_W'(1))); // R5
    AST_EXPIRED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CH_EXPIRED && !ld) |=> !tmr_out); // R7
    AST_RELOAD_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> !tmr_out); // R8
endmodule

// File: rtl/mct_bank.sv
module mct_bank #(
    parameter int N_CH   = 12,
    parameter int CNT_W  = 14,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [N_CH-1:0]   tmr_out
);
    logic [N_CH-1:0] ld_vec;
    logic            arm;

    mct_decode #(.N_CH(N_CH), .ADDR_W(ADDR_W)) i_decode (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .ld_vec(ld_vec), .arm(arm)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        mct_channel #(.CNT_W(CNT_W)) i_ch (
            .clk(clk), .rst_n(rst_n), .ld(ld_vec[c]), .ld_val(wr_data),
            .arm(arm), .tmr_out(tmr_out[c])
        );
    end

    AST_NO_START_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm) |=> ((tmr_out & ~$past(tmr_out)) == '0)); // R9
endmodule

// File: tb/test_mct_bank.sv
`timescale 1ns/1ps
module test_mct_bank;
    localparam int N_CH = 12, CNT_W = 14, ADDR_W = 4;

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [CNT_W-1:0]  wr_data = '0;
    logic [N_CH-1:0]   tmr_out;
    int total = 0, bad = 0;
    int exp_val [N_CH];
    bit exp_live[N_CH];

    always #2.5 clk = ~clk;

    mct_bank #(.N_CH(N_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_mct_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tmr_out(tmr_out)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = CNT_W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load(input int c, input int d);
        wr(c, d);
        exp_val[c] = d; exp_live[c] = 1'b1;
    endtask

    // called right after the arming write; sample k = 0 is the negedge after it
    task automatic sweep(input int len, input string tag);
        for (int k = 0; k <= len; k++) begin
            for (int c = 0; c < N_CH; c++)
                chk(tmr_out[c], exp_live[c] && k >= 1 && k <= exp_val[c],
                    $sformatf("%s ch%0d k=%0d", tag, c, k));
            @(negedge clk);
        end
        for (int c = 0; c < N_CH; c++) exp_live[c] = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < N_CH; c++) begin exp_val[c] = 0; exp_live[c] = 1'b0; end
        repeat (3) @(negedge clk);
        for (int c = 0; c < N_CH; c++) chk(tmr_out[c], 1'b0, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        for (int c = 0; c < N_CH; c++) chk(tmr_out[c], 1'b0, "R1 after reset");

        // R9: only the last channel was written since reset
        load(N_CH-1, 3);
        sweep(6, "R9 unwritten channels stay low");

        // R2/R4/R5/R6: all channels with distinct lengths, ch0 loaded with zero
        for (int c = 0; c < N_CH-1; c++) load(c, c * 3);
        for (int k = 0; k < 5; k++) begin
            for (int c = 0; c < N_CH; c++) chk(tmr_out[c], 1'b0, "R2 loaded waits");
            @(negedge clk);
        end
        load(N_CH-1, 7);
        sweep(36, "R4 R5 R6 full sweep");

        // R7: arm again without reloading the expired channels
        load(N_CH-1, 4);
        sweep(8, "R7 expired stays low");

        // R3: out-of-range addresses change nothing
        for (int a = N_CH; a < (1 << ADDR_W); a++) wr(a, 9);
        load(N_CH-1, 2);
        sweep(12, "R3 ignored address");

        // R5: single-channel length sweep
        for (int n = 1; n <= 6; n++) begin
            load(5, n);
            load(N_CH-1, 0);
            sweep(n + 2, "R5 length sweep");
        end

        // R8: reload a running channel
        load(2, 10);
        load(N_CH-1, 10);
        repeat (3) @(negedge clk);
        wr(2, 5);
        chk(tmr_out[2], 1'b0, "R8 reload stops channel");
        chk(tmr_out[N_CH-1], 1'b1, "R8 other channel keeps running");
        repeat (8) @(negedge clk);
        chk(tmr_out[N_CH-1], 1'b0, "R5 last channel expired");
        chk(tmr_out[2], 1'b0, "R8 reloaded waits for arm");
        exp_val[2] = 5; exp_live[2] = 1'b1;
        for (int c = 0; c < N_CH; c++) if (c != 2) exp_live[c] = 1'b0;
        load(N_CH-1, 1);
        sweep(7, "R8 reloaded value runs");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule